// File: doc/BRIEF.md
# USB Endpoint DMA Burst Engine

This block moves one buffer of USB endpoint data from an endpoint FIFO into system memory through a simple bus master port. Software-side logic loads a start address, a byte count, an endpoint size in bytes and an endpoint type (bulk or isochronous), then pulses `start`. The engine presents one word per beat at incrementing word addresses. Data comes straight from a show-ahead FIFO, and the FIFO is popped whenever a beat is accepted.

The buffer is cut into unbroken bursts. Each burst is as long as the smallest of three limits: the endpoint-type ceiling (128 words for bulk, 256 for isochronous), the endpoint size rounded up to whole words, and the words still left. A bus lock stays high from the first beat of the buffer to its last beat, so no other master can get between its bursts. A byte count that is not a multiple of four ends with a partial word marked by byte strobes. A single-cycle done pulse closes the transfer, and the lock drops in that same cycle.

Top module: `usb_ep_dma_burst`

## Requirements
- R1: While reset is held and right after it, `m_valid`, `m_lock`, `busy`, `done` and `fifo_pop` are all low.
- R2: The first beat goes to `cfg_addr` with its two low bits cleared. Each following beat's address is 4 higher than the one before.
- R3: `m_first` is high on the first beat of each burst, and `m_blen` then holds the burst's beat count. That count is min(type ceiling, endpoint words, words left). The type ceiling is 128 when `cfg_iso`=0 and 256 when `cfg_iso`=1. Endpoint words is ceil(`cfg_ep_size`/4), or 1 when the size is 0.
- R4: `m_lock` is high on every cycle in which `m_valid` is high, and it stays high between bursts of the same buffer.
- R5: `m_strb` is 4'b1111 on every beat except the final one. When the byte count modulo 4 is 1, 2 or 3, the final beat's strobe is 4'b0001, 4'b0011 or 4'b0111 (byte 0 sits in bits 7:0).
- R6: While `m_valid` is high and `m_ready` is low, the next cycle keeps `m_valid` high and keeps `m_addr` and `m_strb` unchanged.
- R7: `done` is high for one cycle, in the cycle after the last beat is accepted. `m_lock` is low in that cycle.
- R8: A start with `cfg_len`=0 raises `done` in the next cycle and produces no beat.
- R9: A `start` pulse while `busy` is high is ignored. The running transfer carries on unchanged and no extra done pulse appears.
- R10: `fifo_pop` is high exactly on accepted beats (`m_valid` and `m_ready`), and `m_wdata` equals `fifo_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer with the cfg_* values |
| cfg_addr | input | ADDR_W | Start byte address (low two bits ignored) |
| cfg_len | input | LEN_W | Buffer length in bytes |
| cfg_ep_size | input | EP_W | Programmed endpoint size in bytes |
| cfg_iso | input | 1 | 1 = isochronous, 0 = bulk |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| m_valid | output | 1 | Beat presented on the master port |
| m_first | output | 1 | Beat opens a new burst |
| m_blen | output | BL_W | Burst beat count, meaningful with m_first |
| m_addr | output | ADDR_W | Word-aligned beat address |
| m_wdata | output | 32 | Beat data |
| m_strb | output | 4 | Byte lane strobes |
| m_lock | output | 1 | Bus lock held over the whole buffer |
| m_ready | input | 1 | Slave accepts the beat |
| fifo_rdata | input | 32 | Head word of the endpoint FIFO |
| fifo_pop | output | 1 | Remove the head word |

## Verification
The hardest case to reach is a stall that lands on a burst boundary or on the partial final word. At that point the engine must keep the burst length it computed and the reduced strobe, even though the remaining-word count it would recompute from has not moved. The stimulus reaches it by driving `m_ready` from a pseudo-random pattern during short-endpoint transfers. In those transfers bursts of one or two words follow each other closely, so many stalls fall on first and last beats. Mixed length and endpoint-size choices then cover every strobe remainder and each of the three burst limits.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;

  // Whole words needed to carry n bytes.
  function automatic logic [31:0] bytes_to_words(logic [31:0] n);
    return (n + 32'd3) >> 2;
  endfunction

  // Endpoint size in words; a zero size still allows single beats.
  function automatic logic [31:0] ep_words(logic [31:0] ep_bytes);
    return (ep_bytes == 32'd0) ? 32'd1 : bytes_to_words(ep_bytes);
  endfunction

  // Smallest of the three burst limits.
  function automatic logic [31:0] pick_burst(logic [31:0] rem,
                                             logic [31:0] epw,
                                             logic [31:0] cap);
    logic [31:0] m;
    m = (rem < epw) ? rem : epw;
    return (m < cap) ? m : cap;
  endfunction

  // Lane mask of the final word given byte count modulo four.
  function automatic logic [3:0] tail_strb(logic [1:0] r);
    case (r)
      2'd1:    return 4'b0001;
      2'd2:    return 4'b0011;
      2'd3:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/ep_dma_sizer.sv
module ep_dma_sizer #(
  parameter int unsigned WCNT_W   = 15,
  parameter int unsigned EP_W     = 11,
  parameter int unsigned BL_W     = 9,
  parameter int unsigned BULK_MAX = 128,
  parameter int unsigned ISO_MAX  = 256
) (
  input  logic [WCNT_W-1:0] rem_words,
  input  logic [EP_W-1:0]   ep_bytes,
  input  logic              iso,
  output logic [BL_W-1:0]   blen
);
  import ep_dma_pkg::*;

  logic [31:0] type_cap;

  always_comb begin
    type_cap = iso ? 32'(ISO_MAX) : 32'(BULK_MAX);
    blen     = BL_W'(pick_burst(32'(rem_words), ep_words(32'(ep_bytes)), type_cap));
  end

endmodule

// File: rtl/ep_dma_addr.sv
module ep_dma_addr #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= load_addr & ~ADDR_W'(3);
    else if (step) addr_q <= addr_q + ADDR_W'(4);
  end

  assign addr = addr_q;

  // R2: every accepted beat moves the address one word up
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> addr == $past(addr) + ADDR_W'(4));

  // R6: without load or step the address stays put
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr));

endmodule

// File: rtl/ep_dma_ctrl.sv
module ep_dma_ctrl #(
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned EP_W     = 11,
  parameter int unsigned WCNT_W   = 15,
  parameter int unsigned BL_W     = 9,
  parameter int unsigned BULK_MAX = 128,
  parameter int unsigned ISO_MAX  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  logic [EP_W-1:0]   ep_bytes,
  input  logic              iso,
  input  logic              m_ready,
  input  logic [BL_W-1:0]   sized_blen,
  output logic [WCNT_W-1:0] rem_words,
  output logic [EP_W-1:0]   ep_q_o,
  output logic              iso_q_o,
  output logic              load,
  output logic              beat_acc,
  output logic              busy,
  output logic              done,
  output logic              first,
  output logic [BL_W-1:0]   blen,
  output logic [3:0]        strb
);
  import ep_dma_pkg::*;

  logic              busy_q, done_q, iso_q;
  logic [WCNT_W-1:0] rem_q;
  logic [BL_W-1:0]   bcnt_q;
  logic [EP_W-1:0]   ep_q;
  logic [1:0]        tail_q;

  // named internal events
  logic start_ok, zero_len, last_beat;

  assign start_ok  = start && !busy_q;
  assign zero_len  = (len == '0);
  assign first     = busy_q && (bcnt_q == '0);
  assign last_beat = busy_q && (rem_q == WCNT_W'(1));
  assign beat_acc  = busy_q && m_ready;
  assign blen      = first ? sized_blen : bcnt_q;
  assign strb      = last_beat ? tail_strb(tail_q) : 4'b1111;
  assign load      = start_ok && !zero_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      iso_q  <= 1'b0;
      rem_q  <= '0;
      bcnt_q <= '0;
      ep_q   <= '0;
      tail_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        if (zero_len) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          rem_q  <= WCNT_W'(bytes_to_words(32'(len)));
          bcnt_q <= '0;
          ep_q   <= ep_bytes;
          iso_q  <= iso;
          tail_q <= len[1:0];
        end
      end else if (beat_acc) begin
        rem_q  <= rem_q - WCNT_W'(1);
        bcnt_q <= blen - BL_W'(1);
        if (last_beat) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign rem_words = rem_q;
  assign ep_q_o    = ep_q;
  assign iso_q_o   = iso_q;
  assign busy      = busy_q;
  assign done      = done_q;

  // R3: an opening burst length respects all three limits
  p_burst_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    first |-> (blen != '0) && (32'(blen) <= (iso_q ? 32'(ISO_MAX) : 32'(BULK_MAX)))
              && (32'(blen) <= 32'(rem_q)));

  // R6: a stalled beat keeps its counters and strobe
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !m_ready) |=> busy_q && $stable(rem_q) && $stable(strb) && $stable(blen));

  // R7: the final accepted beat is followed by done with the engine idle
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_acc && last_beat) |=> done_q && !busy_q);

  // R7: lock (busy) is never up while done is up
  p_done_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // R8: an empty buffer completes at once without becoming busy
  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && zero_len) |=> done_q && !busy_q);

endmodule

// File: rtl/usb_ep_dma_burst.sv
module usb_ep_dma_burst #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned EP_W     = 11,
  parameter int unsigned BULK_MAX = 128,
  parameter int unsigned ISO_MAX  = 256,
  localparam int unsigned WCNT_W  = LEN_W - 1,
  localparam int unsigned BL_W    = $clog2(ISO_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [EP_W-1:0]   cfg_ep_size,
  input  logic              cfg_iso,
  output logic              busy,
  output logic              done,
  output logic              m_valid,
  output logic              m_first,
  output logic [BL_W-1:0]   m_blen,
  output logic [ADDR_W-1:0] m_addr,
  output logic [31:0]       m_wdata,
  output logic [3:0]        m_strb,
  output logic              m_lock,
  input  logic              m_ready,
  input  logic [31:0]       fifo_rdata,
  output logic              fifo_pop
);
  logic [WCNT_W-1:0] rem_words;
  logic [EP_W-1:0]   ep_q;
  logic              iso_q;
  logic [BL_W-1:0]   sized_blen;
  logic              load, beat_acc;

  ep_dma_sizer #(
    .WCNT_W(WCNT_W), .EP_W(EP_W), .BL_W(BL_W),
    .BULK_MAX(BULK_MAX), .ISO_MAX(ISO_MAX)
  ) sizer_i (
    .rem_words(rem_words), .ep_bytes(ep_q), .iso(iso_q), .blen(sized_blen)
  );

  ep_dma_ctrl #(
    .LEN_W(LEN_W), .EP_W(EP_W), .WCNT_W(WCNT_W), .BL_W(BL_W),
    .BULK_MAX(BULK_MAX), .ISO_MAX(ISO_MAX)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .len(cfg_len),
    .ep_bytes(cfg_ep_size), .iso(cfg_iso), .m_ready(m_ready),
    .sized_blen(sized_blen), .rem_words(rem_words), .ep_q_o(ep_q),
    .iso_q_o(iso_q), .load(load), .beat_acc(beat_acc), .busy(busy),
    .done(done), .first(m_first), .blen(m_blen), .strb(m_strb)
  );

  ep_dma_addr #(.ADDR_W(ADDR_W)) addr_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(cfg_addr),
    .step(beat_acc), .addr(m_addr)
  );

  assign m_valid  = busy;
  assign m_lock   = busy;
  assign m_wdata  = fifo_rdata;
  assign fifo_pop = beat_acc;

  // R4: no beat is ever presented without the lock
  p_lock_cover_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> m_lock);

  // R10: pops happen only on handshaken beats
  p_pop_on_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (m_valid && m_ready));

  // R9: a start during a transfer does not reload the address
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !m_ready) |=> $stable(m_addr));

endmodule

// File: tb/usb_ep_dma_burst_tb_top.sv
module usb_ep_dma_burst_tb_top;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LEN_W  = 16;
  localparam int unsigned EP_W   = 11;
  localparam int unsigned BL_W   = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [LEN_W-1:0]  cfg_len = '0;
  logic [EP_W-1:0]   cfg_ep_size = '0;
  logic              cfg_iso = 1'b0;
  logic              busy, done, m_valid, m_first, m_lock, fifo_pop;
  logic [BL_W-1:0]   m_blen;
  logic [ADDR_W-1:0] m_addr;
  logic [31:0]       m_wdata;
  logic [3:0]        m_strb;
  logic              m_ready = 1'b1;
  logic [31:0]       fifo_rdata;

  usb_ep_dma_burst dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr(cfg_addr),
    .cfg_len(cfg_len), .cfg_ep_size(cfg_ep_size), .cfg_iso(cfg_iso),
    .busy(busy), .done(done), .m_valid(m_valid), .m_first(m_first),
    .m_blen(m_blen), .m_addr(m_addr), .m_wdata(m_wdata), .m_strb(m_strb),
    .m_lock(m_lock), .m_ready(m_ready), .fifo_rdata(fifo_rdata),
    .fifo_pop(fifo_pop)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  strb;
    logic        first;
    logic [8:0]  blen;
    logic [31:0] data;
  } beat_t;

  beat_t exp_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;
  int push_idx = 0;
  int pop_idx  = 0;
  bit stall_mode = 1'b0;
  bit finished   = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  assign fifo_rdata = 32'hC0DE_0000 ^ 32'(pop_idx);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ready pattern, driven away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  // Driver: build expected beats by walking the buffer word by word
  task automatic push_expected(input logic [31:0] addr, input int len,
                               input int ep, input bit iso);
    int total, cap, epw, left, in_burst, blen_now;
    logic [31:0] a;
    total = len / 4 + ((len % 4) != 0 ? 1 : 0);
    cap   = iso ? 256 : 128;
    epw   = (ep == 0) ? 1 : (ep + 3) / 4;
    a     = {addr[31:2], 2'b00};
    left  = total;
    in_burst = 0;
    blen_now = 0;
    for (int w = 0; w < total; w++) begin
      beat_t b;
      b.first = (in_burst == 0);
      if (b.first) begin
        blen_now = left;
        if (epw < blen_now) blen_now = epw;
        if (cap < blen_now) blen_now = cap;
        in_burst = blen_now;
      end
      b.blen = 9'(blen_now);
      b.addr = a;
      b.strb = 4'b1111;
      if (w == total - 1 && (len % 4) != 0)
        b.strb = (len % 4 == 1) ? 4'b0001 : (len % 4 == 2) ? 4'b0011 : 4'b0111;
      b.data = 32'hC0DE_0000 ^ 32'(push_idx);
      push_idx++;
      exp_q.push_back(b);
      a = a + 32'd4;
      in_burst--;
      left--;
    end
  endtask

  task automatic run_xfer(input logic [31:0] addr, input int len, input int ep,
                          input bit iso, input bit poke_busy);
    int d0;
    push_expected(addr, len, ep, iso);
    d0 = done_cnt;
    @(posedge clk); #1;
    start = 1'b1; cfg_addr = addr; cfg_len = 16'(len);
    cfg_ep_size = 11'(ep); cfg_iso = iso;
    @(posedge clk); #1;
    start = 1'b0;
    if (len == 0) begin
      check(done == 1'b1 && m_valid == 1'b0, "R8", "zero-length done next cycle",
            {31'd0, done}, 32'd1);
    end
    if (poke_busy) begin
      repeat (3) @(posedge clk);
      #1;
      // R9: restart attempt while busy with a different setup
      start = 1'b1; cfg_addr = 32'h0000_9000; cfg_len = 16'd4;
      cfg_ep_size = 11'd4; cfg_iso = 1'b0;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (done_cnt == d0) @(posedge clk);
    repeat (3) @(posedge clk);
    check(done_cnt == d0 + 1, "R9", "done pulses per transfer", 32'(done_cnt - d0), 32'd1);
    check(exp_q.size() == 0, "R10", "beats left unconsumed", 32'(exp_q.size()), 32'd0);
  endtask

  // Monitor: compare at the falling edge
  bit          prev_stall = 1'b0;
  bit          prev_acc   = 1'b0;
  bit          prev_done  = 1'b0;
  logic [31:0] prev_addr  = '0;
  logic [3:0]  prev_strb  = '0;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin
          check(m_valid == 1'b1, "R6", "valid kept during stall", {31'd0, m_valid}, 32'd1);
          check(m_addr == prev_addr, "R6", "addr held during stall", m_addr, prev_addr);
          check(m_strb == prev_strb, "R6", "strb held during stall", {28'd0, m_strb}, {28'd0, prev_strb});
        end
        if (m_valid)
          check(m_lock == 1'b1, "R4", "lock during beat", {31'd0, m_lock}, 32'd1);
        if (m_valid && m_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected beat", m_addr, 32'hFFFF_FFFF);
          end else begin
            beat_t e;
            e = exp_q.pop_front();
            check(m_addr == e.addr, "R2", "beat address", m_addr, e.addr);
            check(m_strb == e.strb, "R5", "beat strobe", {28'd0, m_strb}, {28'd0, e.strb});
            check(m_first == e.first, "R3", "burst start flag", {31'd0, m_first}, {31'd0, e.first});
            if (e.first)
              check(m_blen == e.blen, "R3", "burst length", {23'd0, m_blen}, {23'd0, e.blen});
            check(m_wdata == e.data, "R10", "beat data", m_wdata, e.data);
            check(fifo_pop == 1'b1, "R10", "pop on accept", {31'd0, fifo_pop}, 32'd1);
          end
          pop_idx++;
        end else begin
          check(fifo_pop == 1'b0, "R10", "no pop without accept", {31'd0, fifo_pop}, 32'd0);
        end
        if (done) begin
          done_cnt++;
          check(m_lock == 1'b0, "R7", "lock released with done", {31'd0, m_lock}, 32'd0);
          check(!prev_done, "R7", "done lasts one cycle", {31'd0, prev_done}, 32'd0);
          if (prev_acc)
            check(exp_q.size() == 0, "R7", "done after final beat", 32'(exp_q.size()), 32'd0);
        end
        prev_stall = m_valid && !m_ready;
        prev_acc   = m_valid && m_ready;
        prev_done  = done;
        prev_addr  = m_addr;
        prev_strb  = m_strb;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R7", "watchdog expired", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!m_valid && !m_lock && !busy && !done && !fifo_pop, "R1", "outputs in reset",
          {27'd0, m_valid, m_lock, busy, done, fifo_pop}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!m_valid && !m_lock && !busy && !done, "R1", "outputs after reset",
          {28'd0, m_valid, m_lock, busy, done}, 32'd0);

    run_xfer(32'h0000_1000, 64, 64, 1'b0, 1'b0);     // one bulk burst
    run_xfer(32'h0002_0000, 1000, 512, 1'b0, 1'b0);  // 128 + 122, bulk ceiling
    run_xfer(32'h0004_0000, 1027, 1024, 1'b1, 1'b0); // 256 + 1, iso ceiling, strb 0111
    stall_mode = 1'b1;
    run_xfer(32'h0000_2000, 30, 8, 1'b0, 1'b0);      // bursts of 2, strb 0011
    run_xfer(32'h0000_3003, 5, 0, 1'b0, 1'b0);       // unaligned, single beats, strb 0001
    run_xfer(32'h0000_4000, 0, 64, 1'b0, 1'b0);      // R8 zero length
    run_xfer(32'h0000_5000, 80, 12, 1'b1, 1'b1);     // R9 start while busy
    run_xfer(32'h0000_6000, 130, 1023, 1'b1, 1'b0);  // remaining words limit
    stall_mode = 1'b0;
    run_xfer(32'h0000_7000, 2, 4, 1'b0, 1'b0);       // strb 0011 on sole beat

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule